// File: doc/BRIEF.md
# Data Access Address Translator and Fault Classifier

This block sits in the load/store path of a processor core. For each data access it takes the virtual address, the access width, the direction and a few request qualifiers, and returns the physical address, an uncacheable marker, one fault class and a six-bit memory-management status word that trap handlers read. The page-table cache itself lives outside: the block sends the virtual page number and the address-space number to it and gets back, in the same cycle, a hit flag, the physical page number and the per-mode enables.

All checks are combinational and run in a fixed order. The result is registered once, so every request gets its response in the following cycle. Misaligned accesses are stopped first. Physical-mode requests bypass translation. Non-canonical addresses, the kernel-only direct-mapped window, lookup misses and the permission and fault-on enables follow in that order. Every translated address then goes through a range check and a cacheability check, which can redirect uncached traffic or reject the internal register window.

Top module: `dtx_xlate`

## Requirements
- R1: A request accepted with `req_valid` high produces `rsp_valid` high on the next clock edge, with that request's results. A cycle without a request produces `rsp_valid` low on the next edge. Reset clears `rsp_valid`.
- R2: Alignment is checked before everything else. If any address bit below the access width is set, the result is class ALIGN (1), where `req_size` 0/1/2/3 means 1/2/4/8 bytes. The status word then holds only the write bit (bit 0), set for stores.
- R3: Modes are encoded kernel=0, executive=1, supervisor=2, user=3, and mode m selects bit m of the enable vectors. When `fw_pc` is high, the mode used for the permission check is `alt_mode` if `req_alt` is set and kernel otherwise. When `fw_pc` is low, it is `cur_mode`.
- R4: A translated access whose bits 63:47 are not all equal gets class PAGE (2). Its status holds bad-address (bit 4) and violation (bit 1), plus the write bit for stores.
- R5: An address with bits 47:41 equal to 0x7E is direct-mapped. If `cur_mode` is not kernel, the access gets class ACV (3) with violation plus the write bit for stores, and this test ignores the firmware override. In kernel mode the physical address is the low 41 bits, with bit 40 copied into bits 43:40.
- R6: A lookup miss sets status bit 5 plus the write bit for stores. It reports class DMISS (5) when `req_ptacc` is set and SMISS (4) otherwise.
- R7: A store whose write enable for the effective mode is clear gets PAGE with write and violation, plus fault-on-write (bit 3) if the entry has it set. If the enable is set but fault-on-write is set, the store gets PAGE with write and fault-on-write only.
- R8: A load whose read enable is clear gets ACV with violation, plus fault-on-read (bit 2) if the entry has it set. If the enable is set but fault-on-read is set, the load gets PAGE with fault-on-read only.
- R9: A permitted hit yields the physical address {ppn, VA[12:0]}. `lkp_vpn` carries VA[47:13] and `lkp_asn` carries `cur_asn` in the same cycle.
- R10: After translation or in physical mode, a full 64-bit address with any bit above 43 set gets class MCHK (6) and status 0.
- R11: If bit 43 of an in-range address is set, an address with bits 43:20 all ones gets class UNIMP (7) and status 0. Otherwise the access succeeds with `rsp_uncache` high and bits 42:35 cleared.
- R12: A physical-mode request uses the virtual address unchanged as its physical address. It skips the canonical, direct-map, lookup and permission checks but still goes through the alignment, range and cacheability checks.
- R13: A successful access reports class NONE (0) and status 0. Any fault reports `rsp_pa` zero and `rsp_uncache` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | log2 of access bytes |
| req_store | input | 1 | 1 = store, 0 = load |
| req_phys | input | 1 | Physical-mode request |
| req_alt | input | 1 | Use alternate mode in firmware |
| req_ptacc | input | 1 | Access is a page-table fetch |
| cur_mode | input | 2 | Current processor mode |
| alt_mode | input | 2 | Alternate mode |
| fw_pc | input | 1 | Executing firmware code |
| cur_asn | input | 8 | Address-space number |
| lkp_vpn | output | 35 | Page number to the lookup |
| lkp_asn | output | 8 | Address-space number to the lookup |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 31 | Physical page number |
| tlb_re | input | 4 | Read enable per mode |
| tlb_we | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Fault-on-read bit |
| tlb_fonw | input | 1 | Fault-on-write bit |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 44 | Physical address |
| rsp_uncache | output | 1 | Access is uncacheable |
| rsp_fault | output | 3 | Fault class |
| rsp_mmstat | output | 6 | Status word |

## Verification
Two conditions often show up on the same access, and in each case only the priority decides the result. In the first case a permission denial and a fault-on bit are both present: the bench marks entries with a cleared enable and a set fault-on bit, and expects the violation class with both status bits set. In the second case an alignment error coincides with a non-canonical address or a missing page: the bench sends misaligned addresses of both kinds and expects ALIGN with only the direction bit. A direct-mapped access in firmware with a user current mode checks that the window test uses the current mode, not the overridden one.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
   typedef enum logic [2:0] {
      FLT_NONE  = 3'd0,
      FLT_ALIGN = 3'd1,
      FLT_PAGE  = 3'd2,
      FLT_ACV   = 3'd3,
      FLT_SMISS = 3'd4,
      FLT_DMISS = 3'd5,
      FLT_MCHK  = 3'd6,
      FLT_UNIMP = 3'd7
   } dtx_fault_e;

   localparam int ST_W     = 6;
   localparam int ST_WR    = 0;
   localparam int ST_ACV   = 1;
   localparam int ST_FONR  = 2;
   localparam int ST_FONW  = 3;
   localparam int ST_BADVA = 4;
   localparam int ST_MISS  = 5;

   localparam int MODE_W   = 2;
   localparam int N_MODES  = 4;
   localparam logic [MODE_W-1:0] MODE_KERN = 2'd0;
endpackage

// File: rtl/dtx_va_chk.sv
module dtx_va_chk #(
   parameter int VA_W    = 64,
   parameter int VA_IMPL = 48,
   parameter int PA_W    = 44,
   parameter int SP_HI   = 47,
   parameter int SP_LO   = 41,
   parameter logic [63:0] SP_TAG = 64'h7E,
   parameter int SP_SX   = 40
) (
   input  logic [VA_W-1:0] va,
   input  logic [1:0]      size,
   output logic            misalign,
   output logic            noncanon,
   output logic            is_sp,
   output logic [VA_W-1:0] sp_pa
);
   localparam int SPW = SP_HI - SP_LO + 1;
   localparam int HIW = VA_W - VA_IMPL + 1;

   logic [2:0]     low_mask;
   logic [HIW-1:0] hi_bits;

   always_comb begin
      case (size)
         2'd0:    low_mask = 3'b000;
         2'd1:    low_mask = 3'b001;
         2'd2:    low_mask = 3'b011;
         default: low_mask = 3'b111;
      endcase
   end

   assign misalign = |(va[2:0] & low_mask);
   assign hi_bits  = va[VA_W-1:VA_IMPL-1];
   assign noncanon = !((&hi_bits) || !(|hi_bits));
   assign is_sp    = (va[SP_HI:SP_LO] == SP_TAG[SPW-1:0]);

   // direct-map window: low bits pass, sign bit replicated up to PA_W-1
   for (genvar b = 0; b < VA_W; b++) begin : g_sp
      if (b < SP_SX) begin : g_low
         assign sp_pa[b] = va[b];
      end else if (b < PA_W) begin : g_ext
         assign sp_pa[b] = va[SP_SX];
      end else begin : g_zero
         assign sp_pa[b] = 1'b0;
      end
   end
endmodule

// File: rtl/dtx_perm.sv
module dtx_perm
   import dtx_pkg::*;
(
   input  logic                  is_store,
   input  logic [MODE_W-1:0]     eff_mode,
   input  logic [N_MODES-1:0]    re,
   input  logic [N_MODES-1:0]    we,
   input  logic                  fonr,
   input  logic                  fonw,
   output logic                  deny,
   output dtx_fault_e            cls,
   output logic [ST_W-1:0]       stat
);
   always_comb begin
      deny = 1'b0;
      cls  = FLT_NONE;
      stat = '0;
      if (is_store) begin
         if (!we[eff_mode]) begin
            deny = 1'b1;
            cls  = FLT_PAGE;
            stat[ST_WR]   = 1'b1;
            stat[ST_ACV]  = 1'b1;
            stat[ST_FONW] = fonw;
         end else if (fonw) begin
            deny = 1'b1;
            cls  = FLT_PAGE;
            stat[ST_WR]   = 1'b1;
            stat[ST_FONW] = 1'b1;
         end
      end else begin
         if (!re[eff_mode]) begin
            deny = 1'b1;
            cls  = FLT_ACV;
            stat[ST_ACV]  = 1'b1;
            stat[ST_FONR] = fonr;
         end else if (fonr) begin
            deny = 1'b1;
            cls  = FLT_PAGE;
            stat[ST_FONR] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dtx_pa_post.sv
module dtx_pa_post #(
   parameter int VA_W   = 64,
   parameter int PA_W   = 44,
   parameter int IPR_LO = 20,
   parameter int UC_HI  = 42,
   parameter int UC_LO  = 35
) (
   input  logic [VA_W-1:0] pa_in,
   output logic            mchk,
   output logic            unimp,
   output logic            uncache,
   output logic [PA_W-1:0] pa_out
);
   logic ucb, ipr;

   assign mchk    = |pa_in[VA_W-1:PA_W];
   assign ucb     = pa_in[PA_W-1];
   assign ipr     = &pa_in[PA_W-1:IPR_LO];
   assign unimp   = !mchk && ucb && ipr;
   assign uncache = !mchk && ucb && !ipr;

   for (genvar b = 0; b < PA_W; b++) begin : g_clr
      if (b >= UC_LO && b <= UC_HI) begin : g_in
         assign pa_out[b] = pa_in[b] & !uncache;
      end else begin : g_out
         assign pa_out[b] = pa_in[b];
      end
   end
endmodule

// File: rtl/dtx_xlate.sv
module dtx_xlate
   import dtx_pkg::*;
#(
   parameter int VA_W    = 64,
   parameter int VA_IMPL = 48,
   parameter int PA_W    = 44,
   parameter int PG_SH   = 13,
   parameter int ASN_W   = 8,
   parameter int IPR_LO  = 20,
   parameter int UC_HI   = 42,
   parameter int UC_LO   = 35,
   parameter int SP_SX   = 40,
   localparam int VPN_W  = VA_IMPL - PG_SH,
   localparam int PPN_W  = PA_W - PG_SH
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_va,
   input  logic [1:0]         req_size,
   input  logic               req_store,
   input  logic               req_phys,
   input  logic               req_alt,
   input  logic               req_ptacc,
   input  logic [1:0]         cur_mode,
   input  logic [1:0]         alt_mode,
   input  logic               fw_pc,
   input  logic [ASN_W-1:0]   cur_asn,
   output logic [VPN_W-1:0]   lkp_vpn,
   output logic [ASN_W-1:0]   lkp_asn,
   input  logic               tlb_hit,
   input  logic [PPN_W-1:0]   tlb_ppn,
   input  logic [3:0]         tlb_re,
   input  logic [3:0]         tlb_we,
   input  logic               tlb_fonr,
   input  logic               tlb_fonw,
   output logic               rsp_valid,
   output logic [PA_W-1:0]    rsp_pa,
   output logic               rsp_uncache,
   output logic [2:0]         rsp_fault,
   output logic [5:0]         rsp_mmstat
);
   if (PA_W > VA_W || VA_IMPL > VA_W || PG_SH >= PA_W) begin : g_bad_width
      $error("dtx_xlate: address widths inconsistent");
   end
   if (UC_HI >= PA_W - 1 || UC_LO > UC_HI || IPR_LO >= PA_W) begin : g_bad_uc
      $error("dtx_xlate: cacheability fields out of range");
   end
   if (SP_SX >= PA_W || VA_IMPL < 48) begin : g_bad_sp
      $error("dtx_xlate: direct-map window does not fit");
   end

   logic              misalign, noncanon, is_sp;
   logic [VA_W-1:0]   sp_pa, hit_pa, pa_sel;
   logic [MODE_W-1:0] eff_mode;
   logic              perm_deny;
   dtx_fault_e        perm_cls;
   logic [ST_W-1:0]   perm_stat;
   logic              mchk, unimp, uncache;
   logic [PA_W-1:0]   post_pa;

   dtx_fault_e        f_nx;
   logic [ST_W-1:0]   st_nx;
   logic [PA_W-1:0]   pa_nx;
   logic              uc_nx;

   assign lkp_vpn  = req_va[VA_IMPL-1:PG_SH];
   assign lkp_asn  = cur_asn;
   assign eff_mode = fw_pc ? (req_alt ? alt_mode : MODE_KERN) : cur_mode;
   assign hit_pa   = VA_W'({tlb_ppn, req_va[PG_SH-1:0]});
   assign pa_sel   = req_phys ? req_va : (is_sp ? sp_pa : hit_pa);

   dtx_va_chk #(
      .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W),
      .SP_HI(47), .SP_LO(41), .SP_TAG(64'h7E), .SP_SX(SP_SX)
   ) va_chk_i (
      .va(req_va), .size(req_size), .misalign(misalign),
      .noncanon(noncanon), .is_sp(is_sp), .sp_pa(sp_pa)
   );

   dtx_perm perm_i (
      .is_store(req_store), .eff_mode(eff_mode), .re(tlb_re), .we(tlb_we),
      .fonr(tlb_fonr), .fonw(tlb_fonw), .deny(perm_deny), .cls(perm_cls),
      .stat(perm_stat)
   );

   dtx_pa_post #(
      .VA_W(VA_W), .PA_W(PA_W), .IPR_LO(IPR_LO), .UC_HI(UC_HI), .UC_LO(UC_LO)
   ) post_i (
      .pa_in(pa_sel), .mchk(mchk), .unimp(unimp), .uncache(uncache),
      .pa_out(post_pa)
   );

   // fixed priority chain
   always_comb begin
      f_nx  = FLT_NONE;
      st_nx = '0;
      pa_nx = '0;
      uc_nx = 1'b0;
      if (misalign) begin
         f_nx = FLT_ALIGN;
         st_nx[ST_WR] = req_store;
      end else if (!req_phys && noncanon) begin
         f_nx = FLT_PAGE;
         st_nx[ST_WR]    = req_store;
         st_nx[ST_BADVA] = 1'b1;
         st_nx[ST_ACV]   = 1'b1;
      end else if (!req_phys && is_sp && cur_mode != MODE_KERN) begin
         f_nx = FLT_ACV;
         st_nx[ST_WR]  = req_store;
         st_nx[ST_ACV] = 1'b1;
      end else if (!req_phys && !is_sp && !tlb_hit) begin
         f_nx = req_ptacc ? FLT_DMISS : FLT_SMISS;
         st_nx[ST_WR]   = req_store;
         st_nx[ST_MISS] = 1'b1;
      end else if (!req_phys && !is_sp && perm_deny) begin
         f_nx  = perm_cls;
         st_nx = perm_stat;
      end else if (mchk) begin
         f_nx = FLT_MCHK;
      end else if (unimp) begin
         f_nx = FLT_UNIMP;
      end else begin
         pa_nx = post_pa;
         uc_nx = uncache;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_pa      <= '0;
         rsp_uncache <= 1'b0;
         rsp_fault   <= '0;
         rsp_mmstat  <= '0;
      end else begin
         rsp_valid   <= req_valid;
         rsp_pa      <= pa_nx;
         rsp_uncache <= uc_nx;
         rsp_fault   <= f_nx;
         rsp_mmstat  <= st_nx;
      end
   end
endmodule

// File: rtl/dtx_xlate_chk.sv
module dtx_xlate_chk #(
   parameter int PA_W  = 44,
   parameter int UC_HI = 42,
   parameter int UC_LO = 35
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_pa,
   input logic            rsp_uncache,
   input logic [2:0]      rsp_fault,
   input logic [5:0]      rsp_mmstat
);
   // R1
   rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R1
   no_rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R2
   align_stat_only_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 3'd1) |-> (rsp_mmstat[5:1] == 5'd0));
   // R6
   miss_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_fault == 3'd4 || rsp_fault == 3'd5)) |-> rsp_mmstat[5]);
   // R10
   late_fault_no_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault[2:1] == 2'b11) |-> (rsp_mmstat == 6'd0));
   // R11
   uc_field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_uncache) |-> (rsp_pa[UC_HI:UC_LO] == '0 && rsp_pa[PA_W-1]));
   // R13
   fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pa == '0 && !rsp_uncache));
   // R13
   ok_stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 3'd0) |-> (rsp_mmstat == 6'd0));
endmodule

bind dtx_xlate dtx_xlate_chk #(.PA_W(PA_W), .UC_HI(UC_HI), .UC_LO(UC_LO)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
   .rsp_pa(rsp_pa), .rsp_uncache(rsp_uncache), .rsp_fault(rsp_fault),
   .rsp_mmstat(rsp_mmstat)
);

// File: tb/dtx_xlate_tb.sv
module dtx_xlate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_va = '0;
   logic [1:0]  req_size = '0;
   logic        req_store = 1'b0, req_phys = 1'b0, req_alt = 1'b0, req_ptacc = 1'b0;
   logic [1:0]  cur_mode = '0, alt_mode = '0;
   logic        fw_pc = 1'b0;
   logic [7:0]  cur_asn = 8'h5A;
   logic [34:0] lkp_vpn;
   logic [7:0]  lkp_asn;
   logic        tlb_hit = 1'b0;
   logic [30:0] tlb_ppn = '0;
   logic [3:0]  tlb_re = '0, tlb_we = '0;
   logic        tlb_fonr = 1'b0, tlb_fonw = 1'b0;
   logic        rsp_valid;
   logic [43:0] rsp_pa;
   logic        rsp_uncache;
   logic [2:0]  rsp_fault;
   logic [5:0]  rsp_mmstat;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   typedef struct {
      string       tag;
      logic [43:0] pa;
      logic        uc;
      logic [2:0]  f;
      logic [5:0]  st;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   dtx_xlate dut_i (.*);

   // expected result derived from the requirement list
   function automatic exp_t model(string tag, logic [63:0] va, logic [1:0] sz,
         logic st, logic ph, logic alt, logic pt, logic [1:0] cm, logic [1:0] am,
         logic fw, logic hit, logic [30:0] ppn, logic [3:0] re, logic [3:0] we,
         logic fr, logic fwb);
      exp_t e;
      logic [63:0] p;
      logic [1:0]  em;
      bit          post;
      e.tag = tag; e.pa = '0; e.uc = 1'b0; e.f = 3'd0; e.st = '0;
      post = 1'b0;
      p = '0;
      em = fw ? (alt ? am : 2'd0) : cm;
      if ((va & ((64'd1 << sz) - 64'd1)) != 0) begin
         e.f = 3'd1; e.st = {5'd0, st};
      end else if (ph) begin
         p = va; post = 1'b1;
      end else if (!(va[63:47] == '0 || va[63:47] == '1)) begin
         e.f = 3'd2; e.st = 6'h12 | {5'd0, st};
      end else if (va[47:41] == 7'h7E) begin
         if (cm != 2'd0) begin
            e.f = 3'd3; e.st = 6'h02 | {5'd0, st};
         end else begin
            p = {20'd0, {4{va[40]}}, va[39:0]}; post = 1'b1;
         end
      end else if (!hit) begin
         e.f = pt ? 3'd5 : 3'd4; e.st = 6'h20 | {5'd0, st};
      end else if (st && !we[em]) begin
         e.f = 3'd2; e.st = fwb ? 6'h0B : 6'h03;
      end else if (st && fwb) begin
         e.f = 3'd2; e.st = 6'h09;
      end else if (!st && !re[em]) begin
         e.f = 3'd3; e.st = fr ? 6'h06 : 6'h02;
      end else if (!st && fr) begin
         e.f = 3'd2; e.st = 6'h04;
      end else begin
         p = {20'd0, ppn, va[12:0]}; post = 1'b1;
      end
      if (post) begin
         if (p[63:44] != 0) e.f = 3'd6;
         else if (p[43] && p[43:20] == 24'hFFFFFF) e.f = 3'd7;
         else if (p[43]) begin
            e.uc = 1'b1; e.pa = p[43:0]; e.pa[42:35] = '0;
         end else e.pa = p[43:0];
      end
      return e;
   endfunction

   task automatic send(string tag, logic [63:0] va, logic [1:0] sz, logic st,
         logic ph, logic alt, logic pt, logic [1:0] cm, logic [1:0] am, logic fw,
         logic hit, logic [30:0] ppn, logic [3:0] re, logic [3:0] we,
         logic fr, logic fwb);
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_size = sz; req_store = st;
      req_phys = ph; req_alt = alt; req_ptacc = pt; cur_mode = cm;
      alt_mode = am; fw_pc = fw; tlb_hit = hit; tlb_ppn = ppn;
      tlb_re = re; tlb_we = we; tlb_fonr = fr; tlb_fonw = fwb;
      sb.push_back(model(tag, va, sz, st, ph, alt, pt, cm, am, fw, hit, ppn,
                         re, we, fr, fwb));
      #1;
      // R9: lookup outputs follow the request in the same cycle
      checks++;
      if (lkp_vpn != va[47:13] || lkp_asn != cur_asn) begin
         errors++;
         $display("FAIL R9 lookup %s: vpn=%h asn=%h expected vpn=%h asn=%h",
                  tag, lkp_vpn, lkp_asn, va[47:13], cur_asn);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: compare each response against the queue head
   always @(negedge clk) begin
      #2;
      if (rst_n && rsp_valid) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R1 response with empty scoreboard: pa=%h expected none", rsp_pa);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_pa !== e.pa || rsp_uncache !== e.uc ||
                rsp_fault !== e.f || rsp_mmstat !== e.st) begin
               errors++;
               $display("FAIL %s: pa=%h uc=%b f=%0d st=%h expected pa=%h uc=%b f=%0d st=%h",
                        e.tag, rsp_pa, rsp_uncache, rsp_fault, rsp_mmstat,
                        e.pa, e.uc, e.f, e.st);
            end
         end
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: rsp_valid=%b expected 0", rsp_valid);
      end
      rst_n = 1'b1;
      // R9 permitted hit, kernel load, 4 bytes
      send("R9 hit load", 64'h0000_0000_1234_5678, 2'd2, 0,0,0,0, 2'd0,2'd0,0, 1, 31'h0000_1234, 4'hF,4'hF, 0,0);
      // R9 store hit back-to-back, user mode
      send("R9 hit store", 64'h0000_7FFF_0000_1FF8, 2'd3, 1,0,0,0, 2'd3,2'd0,0, 1, 31'h0ABC_DEF0, 4'h8,4'h8, 0,0);
      // R2 misaligned store also non-canonical: alignment wins
      send("R2 align beats badva", 64'h0000_8000_0000_0004, 2'd3, 1,0,0,0, 2'd0,2'd0,0, 0, '0, 4'h0,4'h0, 0,0);
      // R2 misaligned load also missing
      send("R2 align beats miss", 64'h0000_0000_0000_0001, 2'd1, 0,0,0,1, 2'd0,2'd0,0, 0, '0, 4'h0,4'h0, 0,0);
      idle();
      // R4 non-canonical store and load
      send("R4 badva store", 64'h0000_8000_0000_0000, 2'd3, 1,0,0,0, 2'd0,2'd0,0, 1, '0, 4'hF,4'hF, 0,0);
      send("R4 badva load", 64'h8000_0000_0000_0010, 2'd0, 0,0,0,0, 2'd0,2'd0,0, 1, '0, 4'hF,4'hF, 0,0);
      // R5 direct-map outside kernel
      send("R5 sp user store", 64'hFFFF_FC00_0000_1000, 2'd3, 1,0,0,0, 2'd3,2'd0,0, 0, '0, 4'h0,4'h0, 0,0);
      send("R5 sp fw still cur mode", 64'hFFFF_FC00_0000_1000, 2'd3, 0,0,0,0, 2'd3,2'd0,1, 0, '0, 4'h0,4'h0, 0,0);
      // R5 kernel direct-map, bit 40 clear
      send("R5 sp kernel", 64'hFFFF_FC12_3456_7000, 2'd2, 0,0,0,0, 2'd0,2'd0,0, 0, '0, 4'h0,4'h0, 0,0);
      // R5 R11 bit 40 set -> extends to 43, uncached with field cleared
      send("R11 sp uncached", 64'hFFFF_FD7F_0000_1000, 2'd3, 0,0,0,0, 2'd0,2'd0,0, 0, '0, 4'h0,4'h0, 0,0);
      // R11 internal register window
      send("R11 sp ipr unimp", 64'hFFFF_FDFF_FFF0_0000, 2'd3, 0,0,0,0, 2'd0,2'd0,0, 0, '0, 4'h0,4'h0, 0,0);
      // R6 misses
      send("R6 single miss load", 64'h0000_0000_0040_0000, 2'd3, 0,0,0,0, 2'd0,2'd0,0, 0, '0, 4'hF,4'hF, 0,0);
      send("R6 double miss store", 64'h0000_0000_0040_0000, 2'd3, 1,0,0,1, 2'd0,2'd0,0, 0, '0, 4'hF,4'hF, 0,0);
      // R7 store permissions
      send("R7 we clear with fonw", 64'h0000_0000_0002_0000, 2'd3, 1,0,0,0, 2'd3,2'd0,0, 1, 31'h11, 4'hF,4'h7, 0,1);
      send("R7 we clear no fonw", 64'h0000_0000_0002_0000, 2'd3, 1,0,0,0, 2'd3,2'd0,0, 1, 31'h11, 4'hF,4'h7, 0,0);
      send("R7 fonw only", 64'h0000_0000_0002_0000, 2'd3, 1,0,0,0, 2'd3,2'd0,0, 1, 31'h11, 4'hF,4'hF, 0,1);
      // R8 load permissions
      send("R8 re clear with fonr", 64'h0000_0000_0002_0000, 2'd3, 0,0,0,0, 2'd1,2'd0,0, 1, 31'h11, 4'hD,4'hF, 1,0);
      send("R8 re clear no fonr", 64'h0000_0000_0002_0000, 2'd3, 0,0,0,0, 2'd1,2'd0,0, 1, 31'h11, 4'hD,4'hF, 0,0);
      send("R8 fonr only", 64'h0000_0000_0002_0000, 2'd3, 0,0,0,0, 2'd1,2'd0,0, 1, 31'h11, 4'hF,4'hF, 1,0);
      // R3 firmware override: user cur mode, kernel-only entry
      send("R3 fw kernel ok", 64'h0000_0000_0003_0008, 2'd3, 1,0,0,0, 2'd3,2'd3,1, 1, 31'h22, 4'h1,4'h1, 0,0);
      send("R3 fw alt user denied", 64'h0000_0000_0003_0008, 2'd3, 1,0,1,0, 2'd0,2'd3,1, 1, 31'h22, 4'h1,4'h1, 0,0);
      send("R3 no fw uses cur", 64'h0000_0000_0003_0008, 2'd3, 0,0,1,0, 2'd2,2'd0,0, 1, 31'h22, 4'h4,4'h0, 0,0);
      // R9 R11 hit with ppn reaching bit 43 -> uncached
      send("R11 hit uncached", 64'h0000_0000_0000_0040, 2'd3, 0,0,0,0, 2'd0,2'd0,0, 1, 31'h7FC0_0001, 4'hF,4'hF, 0,0);
      // R12 physical mode skips translation checks
      send("R12 phys plain", 64'h0000_0123_4567_89A0, 2'd3, 1,1,0,0, 2'd3,2'd0,0, 0, '0, 4'h0,4'h0, 0,0);
      send("R10 phys out of range", 64'h0000_1000_0000_0000, 2'd3, 0,1,0,0, 2'd0,2'd0,0, 0, '0, 4'h0,4'h0, 0,0);
      send("R12 phys ipr", 64'h0000_0FFF_FFF0_0040, 2'd3, 0,1,0,0, 2'd0,2'd0,0, 0, '0, 4'h0,4'h0, 0,0);
      send("R12 phys misaligned", 64'h0000_0000_0000_0002, 2'd2, 1,1,0,0, 2'd0,2'd0,0, 0, '0, 4'h0,4'h0, 0,0);
      idle();
      idle();
      repeat (3) @(negedge clk);
      // R1 every request answered
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R1 outstanding responses: %0d expected 0", sb.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule